// File: doc/BRIEF.md
# Multi-Channel Serial Register Hub with Interrupt Combiner

This block is the register front end of a serial controller that holds up to sixteen UART channels. They all sit behind a single 32-bit memory-mapped window of 16 KB. Each bus access goes to one of three places:

- a small global register file;
- the register port of one UART channel;
- nowhere, in which case a read returns zero and a write is dropped.

The global file carries the following registers:

- a fixed identification word;
- the channel count;
- a read-only interrupt status word that mirrors the channels' request lines;
- an interrupt enable mask and a wake mask. Software changes each mask only through a pair of set and clear addresses.

The block merges the per-channel interrupt requests into one level-sensitive interrupt output, gated by the enable mask.

Each channel sees a select strobe, a write enable, an 8-bit local offset and the write data. It returns read data in the same cycle. The hub registers that read data into a one-cycle response with a valid flag. Channels beyond the configured count, and the upper (DMA) half of every channel window, read as zero and never receive a select.

Top module: `uart_hub_front`

## Requirements
- R1: A read at byte offset 0x00 returns 0x00070002, and a read at 0x04 returns the channel count parameter `NUM_CH` (1 to 16, default 16).
- R2: A write to 0x0C ORs the data into the enable mask, and a write to 0x10 clears every enable bit that is set in the data. A read of 0x0C returns the mask, and a read of 0x10 returns its bitwise inverse.
- R3: The wake mask follows the same rules at 0x14 (set) and 0x18 (clear, read back inverted). It never changes the interrupt output.
- R4: Bit i of the status word (read at 0x08) equals the request line of channel i as sampled at the previous clock edge. Bits at and above `NUM_CH` read zero.
- R5: `irq_out` is high exactly when the status word AND the enable mask is nonzero. It follows an enable change with no extra cycle.
- R6: Offsets below 0x1000 are decoded on address bits [11:2]. Writes to 0x00, 0x04, 0x08 or any undefined global word change nothing. Reads of undefined global words return zero.
- R7: From 0x1000 upward, the channel index is (addr-0x1000)>>9 and the local offset is the low 9 bits of (addr-0x1000). A valid access raises only `ch_sel[index]`, drives `ch_addr` with local bits [7:0], and drives `ch_we`/`ch_wdata` from the bus. A read returns that channel's `ch_rdata` word.
- R8: A local offset of 0x100 or more (bit 8 set) is the DMA half. No select is raised, reads return zero and writes are dropped.
- R9: A channel index at or above `NUM_CH` raises no select, and reads there return zero.
- R10: While `rst_n` is low, `ch_rst` is all ones and the status word and both masks are cleared. `ch_rst` is all zeros once `rst_n` is high.
- R11: `bus_rvalid` is high for exactly the cycle after a read strobe, with `bus_rdata` holding the response. A write strobe produces no `bus_rvalid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_req | input | 1 | Access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 14 | Byte offset into the 16 KB window |
| bus_wdata | input | 32 | Write data |
| bus_rvalid | output | 1 | Read response valid, one cycle after a read strobe |
| bus_rdata | output | 32 | Read response data |
| irq_out | output | 1 | Combined level interrupt |
| ch_rst | output | NUM_CH | Reset to each channel, active high |
| ch_sel | output | NUM_CH | Per-channel select strobe |
| ch_we | output | 1 | Write enable to channels |
| ch_addr | output | 8 | Local register offset to channels |
| ch_wdata | output | 32 | Write data to channels |
| ch_rdata | input | NUM_CH*32 | Same-cycle read data, channel i in bits [32i+31:32i] |
| ch_irq | input | NUM_CH | Interrupt request level of each channel |

## Verification
Random streams drive the block with global accesses over both defined and undefined words, and with channel-window accesses over all 24 window slots. This separates correct index and offset arithmetic from an off-by-one error. It also shows whether the DMA half and the out-of-range slots are kept quiet. Random set and clear writes to both masks are interleaved with random changes of the request lines. The interrupt output is compared after every step, which tells an enable-gated merge apart from one that also listens to the wake mask or ignores the enable mask. Directed cases cover writes to the read-only words, the all-ones clear, and the reset values.

// File: rtl/uart_hub_pkg.sv
package uart_hub_pkg;

  localparam int unsigned BUS_DW     = 32;
  localparam int unsigned WIN_BASE   = 32'h1000;
  localparam int unsigned WIN_SHIFT  = 9;
  localparam int unsigned LOCAL_W    = 8;
  localparam int unsigned GWORD_W    = 10;

  localparam logic [BUS_DW-1:0] HUB_ID_WORD = 32'h0007_0002;

  // global word offsets (byte offset >> 2)
  localparam logic [GWORD_W-1:0] GW_IDENT  = 10'd0;
  localparam logic [GWORD_W-1:0] GW_COUNT  = 10'd1;
  localparam logic [GWORD_W-1:0] GW_STATUS = 10'd2;
  localparam logic [GWORD_W-1:0] GW_EN_SET = 10'd3;
  localparam logic [GWORD_W-1:0] GW_EN_CLR = 10'd4;
  localparam logic [GWORD_W-1:0] GW_WK_SET = 10'd5;
  localparam logic [GWORD_W-1:0] GW_WK_CLR = 10'd6;

  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_GLOB = 2'd1,
    TGT_CHAN = 2'd2
  } hub_tgt_e;

  function automatic int unsigned win_index(input int unsigned a);
    return (a - WIN_BASE) >> WIN_SHIFT;
  endfunction

  function automatic int unsigned win_local(input int unsigned a);
    return (a - WIN_BASE) & ((32'd1 << WIN_SHIFT) - 32'd1);
  endfunction

  function automatic logic [BUS_DW-1:0] mask_update(input logic [BUS_DW-1:0] cur,
                                                    input logic [BUS_DW-1:0] d,
                                                    input logic              set);
    return set ? (cur | d) : (cur & ~d);
  endfunction

endpackage

// File: rtl/uart_hub_decode.sv
module uart_hub_decode
  import uart_hub_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int ADDR_W = 14,
  parameter int IDX_W  = ADDR_W - 9
) (
  input  logic                   req,
  input  logic [ADDR_W-1:0]      addr,
  output hub_tgt_e               tgt,
  output logic [GWORD_W-1:0]     glob_word,
  output logic [IDX_W-1:0]       ch_idx,
  output logic [WIN_SHIFT-1:0]   ch_local,
  output logic                   dma_hit,
  output logic                   beyond_hit,
  output logic [NUM_CH-1:0]      ch_sel
);

  int unsigned a_ext;
  int unsigned idx_full;
  int unsigned loc_full;

  always_comb begin
    a_ext      = 32'(addr);
    idx_full   = win_index(a_ext);
    loc_full   = win_local(a_ext);
    tgt        = TGT_NONE;
    glob_word  = '0;
    ch_idx     = '0;
    ch_local   = '0;
    dma_hit    = 1'b0;
    beyond_hit = 1'b0;
    if (a_ext < WIN_BASE) begin
      tgt       = TGT_GLOB;
      glob_word = addr[11:2];
    end else begin
      ch_idx     = IDX_W'(idx_full);
      ch_local   = WIN_SHIFT'(loc_full);
      dma_hit    = ch_local[WIN_SHIFT-1];
      beyond_hit = (idx_full >= 32'(NUM_CH));
      if (!dma_hit && !beyond_hit)
        tgt = TGT_CHAN;
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_sel
    assign ch_sel[g] = req && (tgt == TGT_CHAN) && (ch_idx == IDX_W'(g));
  end

endmodule

// File: rtl/uart_hub_glob_regs.sv
module uart_hub_glob_regs
  import uart_hub_pkg::*;
#(
  parameter int NUM_CH = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_stb,
  input  logic [GWORD_W-1:0]   word,
  input  logic [BUS_DW-1:0]    wdata,
  input  logic [NUM_CH-1:0]    ch_irq,
  output logic [BUS_DW-1:0]    en_q,
  output logic [BUS_DW-1:0]    wake_q,
  output logic [BUS_DW-1:0]    sts_q,
  output logic [BUS_DW-1:0]    rd_glob,
  output logic                 irq_out,
  output logic                 en_wr_ev,
  output logic                 wk_wr_ev
);

  localparam int PAD_W = BUS_DW - NUM_CH;

  logic en_set, en_clr, wk_set, wk_clr;

  assign en_set   = wr_stb && (word == GW_EN_SET);
  assign en_clr   = wr_stb && (word == GW_EN_CLR);
  assign wk_set   = wr_stb && (word == GW_WK_SET);
  assign wk_clr   = wr_stb && (word == GW_WK_CLR);
  assign en_wr_ev = en_set || en_clr;
  assign wk_wr_ev = wk_set || wk_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      wake_q <= '0;
      sts_q  <= '0;
    end else begin
      sts_q <= {{PAD_W{1'b0}}, ch_irq};
      if (en_wr_ev) en_q   <= mask_update(en_q, wdata, en_set);
      if (wk_wr_ev) wake_q <= mask_update(wake_q, wdata, wk_set);
    end
  end

  always_comb begin
    case (word)
      GW_IDENT:  rd_glob = HUB_ID_WORD;
      GW_COUNT:  rd_glob = BUS_DW'(NUM_CH);
      GW_STATUS: rd_glob = sts_q;
      GW_EN_SET: rd_glob = en_q;
      GW_EN_CLR: rd_glob = ~en_q;
      GW_WK_SET: rd_glob = wake_q;
      GW_WK_CLR: rd_glob = ~wake_q;
      default:   rd_glob = '0;
    endcase
  end

  assign irq_out = |(sts_q & en_q);

endmodule

// File: rtl/uart_hub_rsp.sv
module uart_hub_rsp
  import uart_hub_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_stb,
  input  hub_tgt_e           tgt,
  input  logic [BUS_DW-1:0]  rd_glob,
  input  logic [BUS_DW-1:0]  rd_chan,
  output logic               rvalid,
  output logic [BUS_DW-1:0]  rdata
);

  logic [BUS_DW-1:0] rd_sel;

  always_comb begin
    unique case (tgt)
      TGT_GLOB: rd_sel = rd_glob;
      TGT_CHAN: rd_sel = rd_chan;
      default:  rd_sel = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      rvalid <= rd_stb;
      rdata  <= rd_stb ? rd_sel : '0;
    end
  end

endmodule

// File: rtl/uart_hub_front.sv
module uart_hub_front
  import uart_hub_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int ADDR_W = 14
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_req,
  input  logic                     bus_we,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [31:0]              bus_wdata,
  output logic                     bus_rvalid,
  output logic [31:0]              bus_rdata,
  output logic                     irq_out,
  output logic [NUM_CH-1:0]        ch_rst,
  output logic [NUM_CH-1:0]        ch_sel,
  output logic                     ch_we,
  output logic [7:0]               ch_addr,
  output logic [31:0]              ch_wdata,
  input  logic [NUM_CH*32-1:0]     ch_rdata,
  input  logic [NUM_CH-1:0]        ch_irq
);

  localparam int IDX_W = ADDR_W - WIN_SHIFT;

  hub_tgt_e               dec_tgt;
  logic [GWORD_W-1:0]     dec_gword;
  logic [IDX_W-1:0]       dec_idx;
  logic [WIN_SHIFT-1:0]   dec_local;
  logic                   dec_dma_hit;
  logic                   dec_beyond_hit;
  logic                   glob_wr_stb;
  logic                   rd_stb;
  logic [BUS_DW-1:0]      en_q, wake_q, sts_q, rd_glob, rd_chan;
  logic                   en_wr_ev, wk_wr_ev;
  logic [BUS_DW-1:0]      ch_word [NUM_CH];

  uart_hub_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_dec (
    .req        (bus_req),
    .addr       (bus_addr),
    .tgt        (dec_tgt),
    .glob_word  (dec_gword),
    .ch_idx     (dec_idx),
    .ch_local   (dec_local),
    .dma_hit    (dec_dma_hit),
    .beyond_hit (dec_beyond_hit),
    .ch_sel     (ch_sel)
  );

  assign glob_wr_stb = bus_req && bus_we && (dec_tgt == TGT_GLOB);
  assign rd_stb      = bus_req && !bus_we;

  uart_hub_glob_regs #(.NUM_CH(NUM_CH)) u_glob (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_stb   (glob_wr_stb),
    .word     (dec_gword),
    .wdata    (bus_wdata),
    .ch_irq   (ch_irq),
    .en_q     (en_q),
    .wake_q   (wake_q),
    .sts_q    (sts_q),
    .rd_glob  (rd_glob),
    .irq_out  (irq_out),
    .en_wr_ev (en_wr_ev),
    .wk_wr_ev (wk_wr_ev)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_word
    assign ch_word[g] = ch_rdata[g*BUS_DW +: BUS_DW];
  end

  always_comb begin
    rd_chan = '0;
    for (int i = 0; i < NUM_CH; i++)
      if (ch_sel[i]) rd_chan = rd_chan | ch_word[i];
  end

  uart_hub_rsp u_rsp (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_stb  (rd_stb),
    .tgt     (dec_tgt),
    .rd_glob (rd_glob),
    .rd_chan (rd_chan),
    .rvalid  (bus_rvalid),
    .rdata   (bus_rdata)
  );

  assign ch_we    = bus_we;
  assign ch_addr  = dec_local[LOCAL_W-1:0];
  assign ch_wdata = bus_wdata;
  assign ch_rst   = {NUM_CH{~rst_n}};

endmodule

// File: rtl/uart_hub_checker.sv
module uart_hub_checker #(
  parameter int NUM_CH = 16,
  parameter int ADDR_W = 14
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 bus_req,
  input logic                 bus_we,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic [31:0]          bus_wdata,
  input logic                 bus_rvalid,
  input logic                 irq_out,
  input logic [NUM_CH-1:0]    ch_sel,
  input logic [NUM_CH-1:0]    ch_irq,
  input logic [31:0]          en_q,
  input logic [31:0]          sts_q
);

  logic        in_win;
  int unsigned win_idx;
  logic        wr_en_set, wr_en_clr;

  assign in_win    = 32'(bus_addr) >= 32'h1000;
  assign win_idx   = (32'(bus_addr) - 32'h1000) >> 9;
  assign wr_en_set = bus_req && bus_we && (bus_addr[ADDR_W-1:2] == 12'h003);
  assign wr_en_clr = bus_req && bus_we && (bus_addr[ADDR_W-1:2] == 12'h004);

  assert_sts_follow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> sts_q == 32'($past(ch_irq)));

  assert_sel_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_sel));

  assert_dma_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_win && bus_addr[8]) |-> ch_sel == '0);

  assert_beyond_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_win && win_idx >= 32'(NUM_CH)) |-> ch_sel == '0);

  assert_rvalid_R11: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> bus_rvalid == $past(bus_req && !bus_we));

  assert_en_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_set |=> (en_q & $past(bus_wdata)) == $past(bus_wdata));

  assert_en_clr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_clr |=> (en_q & $past(bus_wdata)) == 32'h0);

  assert_irq_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == 32'h0 || sts_q == 32'h0) |-> !irq_out);

endmodule

bind uart_hub_front uart_hub_checker #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_req    (bus_req),
  .bus_we     (bus_we),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_rvalid (bus_rvalid),
  .irq_out    (irq_out),
  .ch_sel     (ch_sel),
  .ch_irq     (ch_irq),
  .en_q       (en_q),
  .sts_q      (sts_q)
);

// File: tb/uart_hub_front_tb.sv
`timescale 1ns/1ps
module uart_hub_front_tb;

  localparam int N = 16;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            bus_req = 1'b0, bus_we = 1'b0;
  logic [13:0]     bus_addr = '0;
  logic [31:0]     bus_wdata = '0;
  logic            bus_rvalid, irq_out, ch_we;
  logic [31:0]     bus_rdata, ch_wdata;
  logic [N-1:0]    ch_rst, ch_sel;
  logic [7:0]      ch_addr;
  logic [N*32-1:0] ch_rdata;
  logic [N-1:0]    ch_irq = '0;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  logic [31:0] m_en = '0, m_wk = '0;

  always #10 clk = ~clk;

  uart_hub_front u_dut (.*);

  // channel model: word = C3, index, 5A, local offset
  always_comb
    for (int i = 0; i < N; i++)
      ch_rdata[i*32 +: 32] = {8'hC3, 8'(i), 8'h5A, ch_addr};

  function automatic logic [31:0] chan_word(input int i, input int loc);
    return {8'hC3, 8'(i), 8'h5A, 8'(loc)};
  endfunction

  function automatic logic [31:0] exp_read(input logic [13:0] a);
    int w, idx, loc;
    if (a < 14'h1000) begin
      w = int'(a) / 4;
      case (w)
        0: return 32'h0007_0002;
        1: return 32'(N);
        2: return 32'(ch_irq);
        3: return m_en;
        4: return ~m_en;
        5: return m_wk;
        6: return ~m_wk;
        default: return 32'h0;
      endcase
    end
    idx = (int'(a) - 4096) / 512;
    loc = (int'(a) - 4096) % 512;
    if (idx >= N || loc >= 256) return 32'h0;
    return chan_word(idx, loc);
  endfunction

  function automatic logic [N-1:0] exp_sel(input logic [13:0] a);
    int idx, loc;
    if (a < 14'h1000) return '0;
    idx = (int'(a) - 4096) / 512;
    loc = (int'(a) - 4096) % 512;
    if (idx >= N || loc >= 256) return '0;
    return N'(1) << idx;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_write(input logic [13:0] a, input logic [31:0] d);
    if (a < 14'h1000)
      case (int'(a) / 4)
        3: m_en = m_en | d;
        4: m_en = m_en & ~d;
        5: m_wk = m_wk | d;
        6: m_wk = m_wk & ~d;
        default: ;
      endcase
  endtask

  // one access; called and returns at a negative edge
  task automatic access(input logic we, input logic [13:0] a, input logic [31:0] d,
                        input string tag);
    logic [N-1:0] sel;
    logic [31:0]  exp;
    bus_req = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
    #2;
    sel = ch_sel;
    chk(sel == exp_sel(a), {tag, " sel R7/R8/R9"}, 32'(sel), 32'(exp_sel(a)));
    if (sel != '0) begin
      chk(ch_addr == a[7:0] - 8'h00 && ch_we == we && ch_wdata == d,
          {tag, " chan port R7"}, {ch_we, 23'h0, ch_addr}, {we, 23'h0, a[7:0]});
    end
    exp = exp_read(a);
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
    if (we) begin
      chk(!bus_rvalid, {tag, " no rvalid on write R11"}, 32'(bus_rvalid), 32'h0);
      model_write(a, d);
    end else begin
      chk(bus_rvalid, {tag, " rvalid R11"}, 32'(bus_rvalid), 32'h1);
      chk(bus_rdata == exp, {tag, " rdata"}, bus_rdata, exp);
    end
    chk(irq_out == |(32'(ch_irq) & m_en), {tag, " irq R5/R3"}, 32'(irq_out),
        32'(|(32'(ch_irq) & m_en)));
  endtask

  task automatic set_irq(input logic [N-1:0] v);
    ch_irq = v;
    @(negedge clk);
    chk(irq_out == |(32'(v) & m_en), "irq after request change R5", 32'(irq_out),
        32'(|(32'(v) & m_en)));
  endtask

  initial begin
    #(20 * 190000);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    void'($urandom(32'd2417));
    ch_irq = 16'hFFFF;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(ch_rst == '1, "ch_rst during reset R10", 32'(ch_rst), 32'hFFFF);
    chk(!irq_out && !bus_rvalid, "outputs idle in reset R10", {30'h0, irq_out, bus_rvalid}, 32'h0);
    rst_n = 1'b1;
    ch_irq = '0;
    @(negedge clk);
    chk(ch_rst == '0, "ch_rst released R10", 32'(ch_rst), 32'h0);
    access(1'b0, 14'h000C, 0, "R10 enable cleared");
    access(1'b0, 14'h0014, 0, "R10 wake cleared");
    access(1'b0, 14'h0008, 0, "R10 status cleared");
    // R1
    access(1'b0, 14'h0000, 0, "R1 ident");
    access(1'b0, 14'h0004, 0, "R1 count");
    // R6: read-only and undefined global words
    access(1'b1, 14'h0000, 32'hFFFF_FFFF, "R6 write ident");
    access(1'b1, 14'h0004, 32'hFFFF_FFFF, "R6 write count");
    access(1'b1, 14'h0008, 32'hFFFF_FFFF, "R6 write status");
    access(1'b1, 14'h0020, 32'hFFFF_FFFF, "R6 write undefined");
    access(1'b0, 14'h0000, 0, "R6 ident kept");
    access(1'b0, 14'h0008, 0, "R6 status kept");
    access(1'b0, 14'h000C, 0, "R6 enable kept");
    access(1'b0, 14'h0FFC, 0, "R6 undefined reads zero");
    // R3: wake mask without effect on irq
    set_irq(16'h0081);
    access(1'b1, 14'h0014, 32'hFFFF_FFFF, "R3 wake set all");
    access(1'b0, 14'h0018, 0, "R3 wake clr readback");
    chk(!irq_out, "R3 wake does not raise irq", 32'(irq_out), 32'h0);
    // R2 / R5
    access(1'b1, 14'h000C, 32'h0000_0080, "R2 enable set bit7");
    chk(irq_out, "R5 irq with enabled request", 32'(irq_out), 32'h1);
    access(1'b1, 14'h0018, 32'hFFFF_FFFF, "R3 wake clr all");
    chk(irq_out, "R3 wake clear keeps irq", 32'(irq_out), 32'h1);
    access(1'b0, 14'h0010, 0, "R2 enable clr readback");
    access(1'b1, 14'h0010, 32'hFFFF_FFFF, "R2 enable clr all");
    chk(!irq_out, "R5 irq low after clear", 32'(irq_out), 32'h0);
    set_irq(16'h0000);
    // R7 / R8 / R9 boundaries
    access(1'b0, 14'h1000, 0, "R7 first channel");
    access(1'b0, 14'h2EFC, 0, "R7 last channel top word");
    access(1'b1, 14'h1A44, 32'h1234_5678, "R7 channel write");
    access(1'b0, 14'h1100, 0, "R8 dma half read");
    access(1'b1, 14'h13FC, 32'hDEAD_BEEF, "R8 dma half write");
    access(1'b0, 14'h3000, 0, "R9 beyond count read");
    access(1'b1, 14'h3E10, 32'hCAFE_0001, "R9 beyond count write");
    // random mix
    for (int k = 0; k < 600; k++) begin
      int cls;
      logic [13:0] a;
      logic [31:0] d;
      cls = int'($urandom % 4);
      d = $urandom;
      case (cls)
        0: begin
          a = 14'(($urandom % 10) * 4);
          access(1'($urandom % 2), a, d, "R6 random global");
        end
        1: begin
          a = 14'(4096 + ($urandom % 24) * 512 + ($urandom % 512));
          access(1'($urandom % 2), a, d, "R7 random window");
        end
        2: begin
          a = 14'(12 + ($urandom % 4) * 4);
          access(1'b1, a, d, "R2 random mask write");
          access(1'b0, a, 0, "R2 random mask read");
        end
        default: begin
          set_irq(N'($urandom));
          access(1'b0, 14'h0008, 0, "R4 random status");
        end
      endcase
    end
    r = 0;
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule